// File: doc/BRIEF.md
# Panel Switch Scanner

The scanner reads the front-panel controls of a step sequencer on a fixed periodic tick. Each tick opens a service window with two phases. In the status phase the active-low status gate is enabled and every scan line is held high. At the end of this phase the three transport inputs (tempo clock, start/stop, tap) are captured. In the scan phase exactly one of four scan lines is pulled low. At the end of that phase the four step switches and the function switches of that line's group are captured. The rest of the period is idle time for the main program. The line pulled low advances by one on every tick. The transport status is therefore refreshed on every tick, and each switch group is refreshed on every fourth tick.

While its line is active, a closed step switch sets the matching step LED drive bit. That bit stays set until the next tick begins, so the LEDs of the group just scanned stay lit for almost the whole period. The period, the status phase length and the scan phase length are parameters counted in clock cycles. A one-cycle strobe marks each freshly captured status word and each freshly captured group word, and the group word carries its group index. No debouncing is done.

Control is a three-state machine:
- STAT_PH: the status gate is enabled. At the last status cycle it moves to SCAN_PH and captures the status word.
- SCAN_PH: one scan line is low. At the last scan cycle it moves to IDLE_PH and captures the group word.
- IDLE_PH: the remaining cycles of the period. At the last cycle of the period it moves back to STAT_PH, clears the LED drive and advances the group.

Reset places the machine in STAT_PH at the first cycle of a period, with group 0 selected.

Top module: `panel_scan_ctrl`

## Requirements
- R1: While reset is held, all scan lines are high, both strobes are low, and the status word, group word, group index and LED drive are zero. The first cycle after reset release is cycle 0 of a period, and group 0 is selected.
- R2: Counting cycles from 0 within each period of TICK_CYC cycles, the status gate output is low for cycles 0 to STAT_CYC-1 and high in every other cycle.
- R3: Scan line g (bit g of the scan output) is the only line driven low during cycles STAT_CYC to STAT_CYC+SCAN_CYC-1. All scan lines are high at every other time, including the whole time the status gate is low.
- R4: The active group is the number of ticks since reset modulo 4: 0 in the first period, then 1, 2, 3, 0 and so on.
- R5: The status word equals the status input value present in the last status cycle (cycle STAT_CYC-1). Bit 0 is tempo clock, bit 1 is start/stop and bit 2 is tap. The status strobe is high only in cycle STAT_CYC, and status input changes at any other cycle do not alter the word.
- R6: The group word holds the step and function inputs present in the last scan cycle (cycle STAT_CYC+SCAN_CYC-1), together with the index of the active group. The group strobe is high only in cycle STAT_CYC+SCAN_CYC. Step bit i is step 4g+i+1. The function bits are: group 0 bit0 mode and bit1 clear; group 1 bit0 prescale and bit1 basic/variation; group 2 bit0 instrument select; group 3 bit0 auto fill-in and bit1 intro/variation.
- R7: LED drive bit 4g+i goes high in the cycle after any scan cycle of group g in which step input i is high. It stays high through the end of the period and is zero from cycle 0 of the next period. Bits of other groups stay zero.
- R8: Step and function inputs outside the scan phase have no effect on the LED drive or on the group word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_in | input | STAT_W (3) | Transport inputs: tempo clock, start/stop, tap |
| step_in | input | STEP_W (4) | Step switch returns of the active line, high = closed |
| func_in | input | FUNC_W (2) | Function switch returns of the active line, high = closed |
| stat_gate_n | output | 1 | Active-low status gate enable |
| scan_n | output | GRP_N (4) | Active-low scan lines |
| status_word | output | STAT_W (3) | Last captured status |
| status_vld | output | 1 | One-cycle strobe for a new status word |
| group_step | output | STEP_W (4) | Last captured step switches |
| group_func | output | FUNC_W (2) | Last captured function switches |
| group_idx | output | GRP_W (2) | Group index of the captured group word |
| group_vld | output | 1 | One-cycle strobe for a new group word |
| led_drv | output | GRP_N*STEP_W (16) | Step LED drive, bit 4g+i for step 4g+i+1 |

## Verification
The bench models a panel whose step and function returns are valid only while a scan line is low. Whenever no line is driven, it puts noise on those inputs. A design that samples or latches outside the scan phase (R8) would therefore show phantom LEDs or a corrupted group word. Status inputs change on every cycle. A capture taken one cycle too early or too late then disagrees with the expected word, and the bench checks the strobe in every cycle for exactly one pulse per period. Step returns also change within a scan phase. This separates the sticky LED OR from the last-cycle group capture, and it catches an LED clear that lands one cycle off the period boundary. Directed ticks with all switches open and with all switches closed, over more than two full rotations, catch an off-by-one group index or a rotation that does not wrap after group 3.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;

    // Phase of the service window inside one tick period.
    typedef enum logic [1:0] {
        STAT_PH = 2'd0,
        SCAN_PH = 2'd1,
        IDLE_PH = 2'd2
    } scan_state_e;

    // Number of scan lines, fixed by the panel wiring.
    localparam int unsigned SCAN_LINES = 4;

endpackage

// File: rtl/scan_period_timer.sv
module scan_period_timer #(
    parameter int unsigned TICK_CYC = 190000,
    parameter int unsigned STAT_CYC = 15000,
    parameter int unsigned SCAN_CYC = 45000
) (
    input  logic clk,
    input  logic rst_n,
    output logic stat_end,
    output logic scan_end,
    output logic period_end
);
    localparam int unsigned CNT_W    = $clog2(TICK_CYC);
    localparam int unsigned SCAN_TOP = STAT_CYC + SCAN_CYC;

    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (period_end) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + CNT_W'(1);
        end
    end

    always_comb begin
        stat_end   = (pos_q == CNT_W'(STAT_CYC - 1));
        scan_end   = (pos_q == CNT_W'(SCAN_TOP - 1));
        period_end = (pos_q == CNT_W'(TICK_CYC - 1));
    end

endmodule

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
    import panel_scan_pkg::*;
#(
    parameter int unsigned GRP_N = SCAN_LINES,
    localparam int unsigned GRP_W = $clog2(GRP_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_end,
    input  logic             scan_end,
    input  logic             period_end,
    output logic             stat_gate_n,
    output logic [GRP_N-1:0] scan_n,
    output logic [GRP_W-1:0] grp,
    output logic             cap_stat,
    output logic             cap_grp,
    output logic             scan_act,
    output logic             led_clr
);
    scan_state_e state_q, state_d;
    logic [GRP_W-1:0] grp_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STAT_PH: if (stat_end)   state_d = SCAN_PH;
            SCAN_PH: if (scan_end)   state_d = IDLE_PH;
            IDLE_PH: if (period_end) state_d = STAT_PH;
            default:                 state_d = STAT_PH;
        endcase
    end

    // State register and group rotation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STAT_PH;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == IDLE_PH && period_end) begin
                grp_q <= (grp_q == GRP_W'(GRP_N - 1)) ? '0 : grp_q + GRP_W'(1);
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        stat_gate_n = 1'b1;
        scan_n      = '1;
        cap_stat    = 1'b0;
        cap_grp     = 1'b0;
        scan_act    = 1'b0;
        led_clr     = 1'b0;
        unique case (state_q)
            STAT_PH: begin
                stat_gate_n = 1'b0;
                cap_stat    = stat_end;
            end
            SCAN_PH: begin
                scan_n   = ~(GRP_N'(1) << grp_q);
                scan_act = 1'b1;
                cap_grp  = scan_end;
            end
            IDLE_PH: begin
                led_clr = period_end;
            end
            default: begin
                stat_gate_n = 1'b1;
            end
        endcase
    end

    assign grp = grp_q;

endmodule

// File: rtl/scan_capture.sv
module scan_capture #(
    parameter int unsigned GRP_N  = 4,
    parameter int unsigned STAT_W = 3,
    parameter int unsigned STEP_W = 4,
    parameter int unsigned FUNC_W = 2,
    localparam int unsigned GRP_W = $clog2(GRP_N),
    localparam int unsigned LED_W = GRP_N * STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stat,
    input  logic              cap_grp,
    input  logic              scan_act,
    input  logic              led_clr,
    input  logic [GRP_W-1:0]  grp,
    input  logic [STAT_W-1:0] status_in,
    input  logic [STEP_W-1:0] step_in,
    input  logic [FUNC_W-1:0] func_in,
    output logic [STAT_W-1:0] status_word,
    output logic              status_vld,
    output logic [STEP_W-1:0] group_step,
    output logic [FUNC_W-1:0] group_func,
    output logic [GRP_W-1:0]  group_idx,
    output logic              group_vld,
    output logic [LED_W-1:0]  led_drv
);
    // Status capture, taken on every tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_word <= '0;
            status_vld  <= 1'b0;
        end else begin
            status_vld <= cap_stat;
            if (cap_stat) status_word <= status_in;
        end
    end

    // Group capture, taken once per tick for the active group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            group_step <= '0;
            group_func <= '0;
            group_idx  <= '0;
            group_vld  <= 1'b0;
        end else begin
            group_vld <= cap_grp;
            if (cap_grp) begin
                group_step <= step_in;
                group_func <= func_in;
                group_idx  <= grp;
            end
        end
    end

    // One sticky LED slice per scan group
    for (genvar g = 0; g < GRP_N; g++) begin : g_led
        logic [STEP_W-1:0] slice_q;
        always_ff @(posedge clk) begin
            if (!rst_n || led_clr) begin
                slice_q <= '0;
            end else if (scan_act && grp == GRP_W'(g)) begin
                slice_q <= slice_q | step_in;
            end
        end
        assign led_drv[g*STEP_W +: STEP_W] = slice_q;
    end

endmodule

// File: rtl/panel_scan_ctrl.sv
module panel_scan_ctrl
    import panel_scan_pkg::*;
#(
    parameter int unsigned TICK_CYC = 190000,
    parameter int unsigned STAT_CYC = 15000,
    parameter int unsigned SCAN_CYC = 45000,
    parameter int unsigned STAT_W   = 3,
    parameter int unsigned STEP_W   = 4,
    parameter int unsigned FUNC_W   = 2,
    localparam int unsigned GRP_N   = SCAN_LINES,
    localparam int unsigned GRP_W   = $clog2(GRP_N),
    localparam int unsigned LED_W   = GRP_N * STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status_in,
    input  logic [STEP_W-1:0] step_in,
    input  logic [FUNC_W-1:0] func_in,
    output logic              stat_gate_n,
    output logic [GRP_N-1:0]  scan_n,
    output logic [STAT_W-1:0] status_word,
    output logic              status_vld,
    output logic [STEP_W-1:0] group_step,
    output logic [FUNC_W-1:0] group_func,
    output logic [GRP_W-1:0]  group_idx,
    output logic              group_vld,
    output logic [LED_W-1:0]  led_drv
);
    logic             stat_end, scan_end, period_end;
    logic [GRP_W-1:0] grp;
    logic             cap_stat, cap_grp, scan_act, led_clr;

    scan_period_timer #(
        .TICK_CYC (TICK_CYC),
        .STAT_CYC (STAT_CYC),
        .SCAN_CYC (SCAN_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_end   (stat_end),
        .scan_end   (scan_end),
        .period_end (period_end)
    );

    scan_phase_fsm #(
        .GRP_N (GRP_N)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_end    (stat_end),
        .scan_end    (scan_end),
        .period_end  (period_end),
        .stat_gate_n (stat_gate_n),
        .scan_n      (scan_n),
        .grp         (grp),
        .cap_stat    (cap_stat),
        .cap_grp     (cap_grp),
        .scan_act    (scan_act),
        .led_clr     (led_clr)
    );

    scan_capture #(
        .GRP_N  (GRP_N),
        .STAT_W (STAT_W),
        .STEP_W (STEP_W),
        .FUNC_W (FUNC_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_stat    (cap_stat),
        .cap_grp     (cap_grp),
        .scan_act    (scan_act),
        .led_clr     (led_clr),
        .grp         (grp),
        .status_in   (status_in),
        .step_in     (step_in),
        .func_in     (func_in),
        .status_word (status_word),
        .status_vld  (status_vld),
        .group_step  (group_step),
        .group_func  (group_func),
        .group_idx   (group_idx),
        .group_vld   (group_vld),
        .led_drv     (led_drv)
    );

endmodule

// File: rtl/panel_scan_chk.sv
module panel_scan_chk #(
    parameter int unsigned GRP_N = 4,
    parameter int unsigned LED_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat_gate_n,
    input logic [GRP_N-1:0] scan_n,
    input logic             status_vld,
    input logic             group_vld,
    input logic [LED_W-1:0] led_drv
);
    logic idle_now;
    assign idle_now = stat_gate_n && (&scan_n);

    assert_gate_lines_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_gate_n |-> (&scan_n));

    assert_one_line_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~scan_n));

    assert_status_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_gate_n) |-> status_vld);

    assert_group_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(&scan_n) && stat_gate_n) |-> group_vld);

    assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_vld && group_vld));

    assert_led_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_gate_n) |-> (led_drv == '0));

    assert_led_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && $past(idle_now)) |-> $stable(led_drv));

endmodule

bind panel_scan_ctrl panel_scan_chk #(
    .GRP_N (GRP_N),
    .LED_W (LED_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_gate_n (stat_gate_n),
    .scan_n      (scan_n),
    .status_vld  (status_vld),
    .group_vld   (group_vld),
    .led_drv     (led_drv)
);

// File: tb/panel_scan_ctrl_bench.sv
module panel_scan_ctrl_bench;
    localparam int TICK = 40;
    localparam int STAT = 6;
    localparam int SCAN = 12;
    localparam int NTICK = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  status_in;
    logic [3:0]  step_in;
    logic [1:0]  func_in;
    logic        stat_gate_n;
    logic [3:0]  scan_n;
    logic [2:0]  status_word;
    logic        status_vld;
    logic [3:0]  group_step;
    logic [1:0]  group_func;
    logic [1:0]  group_idx;
    logic        group_vld;
    logic [15:0] led_drv;

    logic [3:0]  panel_step [4];
    logic [1:0]  panel_func [4];
    logic [3:0]  noise_step;
    logic [1:0]  noise_func;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    panel_scan_ctrl #(
        .TICK_CYC (TICK),
        .STAT_CYC (STAT),
        .SCAN_CYC (SCAN)
    ) u_panel_scan_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_in   (status_in),
        .step_in     (step_in),
        .func_in     (func_in),
        .stat_gate_n (stat_gate_n),
        .scan_n      (scan_n),
        .status_word (status_word),
        .status_vld  (status_vld),
        .group_step  (group_step),
        .group_func  (group_func),
        .group_idx   (group_idx),
        .group_vld   (group_vld),
        .led_drv     (led_drv)
    );

    // Panel model: returns are valid only through a low scan line
    always_comb begin
        step_in = noise_step;
        func_in = noise_func;
        for (int k = 0; k < 4; k++) begin
            if (!scan_n[k]) begin
                step_in = panel_step[k];
                func_in = panel_func[k];
            end
        end
    end

    function automatic logic [3:0] exp_lines(input int t, input int g);
        if (t >= STAT && t < STAT + SCAN) return ~(4'b0001 << g);
        return 4'hF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [2:0]  e_stat;
    logic [3:0]  e_gstep;
    logic [1:0]  e_gfunc;
    logic [1:0]  e_gidx;
    logic [15:0] e_led;

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        status_in = '0;
        noise_step = 4'hF;
        noise_func = 2'h3;
        for (int k = 0; k < 4; k++) begin
            panel_step[k] = '0;
            panel_func[k] = '0;
        end
        e_stat = '0; e_gstep = '0; e_gfunc = '0; e_gidx = '0; e_led = '0;

        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 reset lines", 32'(scan_n), 32'hF);
            chk("R1 reset strobes", 32'({status_vld, group_vld}), 32'h0);
            chk("R1 reset words", 32'({status_word, group_step, group_func, group_idx}), 32'h0);
            chk("R1 reset leds", 32'(led_drv), 32'h0);
        end
        rst_n = 1'b1;

        for (int cyc = 0; cyc < NTICK * TICK; cyc++) begin
            int t;
            int tk;
            int g;
            t  = cyc % TICK;
            tk = cyc / TICK;
            g  = tk % 4;

            chk("R2 status gate", 32'(stat_gate_n), (t < STAT) ? 32'h0 : 32'h1);
            chk("R3 R4 scan lines", 32'(scan_n), 32'(exp_lines(t, g)));
            chk("R5 status strobe", 32'(status_vld), (t == STAT) ? 32'h1 : 32'h0);
            chk("R5 status word", 32'(status_word), 32'(e_stat));
            chk("R6 group strobe", 32'(group_vld), (t == STAT + SCAN) ? 32'h1 : 32'h0);
            chk("R6 R8 group word", 32'({group_idx, group_func, group_step}),
                32'({e_gidx, e_gfunc, e_gstep}));
            chk("R7 R8 led drive", 32'(led_drv), 32'(e_led));

            // Stimulus for this cycle
            status_in  = 3'($urandom);
            noise_step = (tk == 0) ? 4'hF : 4'($urandom);
            noise_func = (tk == 0) ? 2'h3 : 2'($urandom);
            for (int k = 0; k < 4; k++) begin
                if (tk == 0) begin
                    panel_step[k] = 4'h0;
                    panel_func[k] = 2'h0;
                end else if (tk == 1) begin
                    panel_step[k] = 4'hF;
                    panel_func[k] = 2'h3;
                end else begin
                    panel_step[k] = 4'($urandom & $urandom & $urandom);
                    panel_func[k] = 2'($urandom);
                end
            end

            // Expected effect of the coming edge
            if (t == STAT - 1) e_stat = status_in;
            if (t >= STAT && t < STAT + SCAN) e_led[g*4 +: 4] = e_led[g*4 +: 4] | panel_step[g];
            if (t == STAT + SCAN - 1) begin
                e_gstep = panel_step[g];
                e_gfunc = panel_func[g];
                e_gidx  = 2'(g);
            end
            if (t == TICK - 1) e_led = '0;

            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule